// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Slave

This block is the control and front end of a small serial nonvolatile memory that answers a three-wire host bus (select, serial clock, data in) and returns data on one output line. A register array stands in for the storage cells. After the host raises select, clocks that carry a zero on data-in are ignored. The first rising serial clock with data-in high marks the start of a command. A two-bit opcode, an address and, for writes, a data field follow. Reads return a stream of locations. Modify commands run a self-timed programming window once select drops. While that window runs, the output line reports busy or ready.

An organization input chooses between 128 locations of 8 bits and 64 locations of 16 bits. A write-enable latch must be set by its own command before any write or erase has effect. A supply-low input blocks programming from starting. The serial inputs are oversampled on the system clock. The output line is presented as a data bit plus an enable, and the pad turns these into a tri-state driver.

Top module: `nvm3w_slave`

## Requirements
- R1: While select is high and no command is open, rising serial clocks with data-in low are ignored; a command begins at the first rising serial clock with select and data-in both high.
- R2: After the start bit, every bit is taken on a rising serial clock, most significant bit first: a two-bit opcode (10 read, 01 write, 11 erase, 00 special), then the address, then data for writes. For the special opcode, the top two address bits select 11 enable, 00 disable, 10 erase-all or 01 write-all.
- R3: With orgWide low, the address is 7 bits and the data is 8 bits (128 locations). With orgWide high, the address is 6 bits and the data is 16 bits (64 locations).
- R4: A read drives a 0 dummy bit once the last address bit is taken. Each further rising serial clock presents the next data bit, MSB first. After the last bit of a location, the next location follows without a new command, and the address wraps from the top location to 0.
- R5: sdoEnable is low after reset, whenever select is low, and at all times except during a read or a status report.
- R6: Write, erase, write-all and erase-all change nothing unless an enable command was accepted earlier. The disable command and reset clear that permission. A refused command reports no status.
- R7: An erased location reads as all ones. Erase clears one location and erase-all clears every location.
- R8: Write-all stores its data field in every location.
- R9: Programming starts on the clock after select falls following a complete modify command. It takes WORD_CYC cycles for write or erase and BULK_CYC cycles for write-all or erase-all. When select is raised afterwards, the output reports 0 while busy and 1 when ready, until the next start bit.
- R10: Start bits that arrive while programming is in progress are ignored, so no command is taken during that window.
- R11: A modify command whose select falls while lowVdd is high is discarded and reports no status.
- R12: Dropping select before a command's last field bit aborts it with no change to the array and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are sampled on it |
| rstN | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| orgWide | input | 1 | Organization: 0 for 8-bit, 1 for 16-bit locations |
| lowVdd | input | 1 | Supply-low inhibit for programming |
| sdoData | output | 1 | Serial output value |
| sdoEnable | output | 1 | Output driver enable; low means high impedance |

## Verification
The checks assume that cs, sclk and din change synchronously to clk and that each serial clock level lasts at least one clk period. They also assume that orgWide and lowVdd are stable around the select edge that could launch programming, and that orgWide changes only while select is low and the device is idle. The stimulus changes every input on the falling clk edge, holds each serial clock level for two clk periods, and switches organization only between commands after ready has been seen. Because the assertions rely on busy rising only after a select fall, the bench always drops select before it polls status.

// File: rtl/nvm3w_pkg.sv
`timescale 1ns/1ps
package nvm3w_pkg;
  typedef enum logic [1:0] {MOD_WRITE, MOD_ERASE, MOD_FILL, MOD_CLEAR} modKind_t;

  typedef struct packed {
    logic     shiftEn;
    logic     adrLatch;
    logic     datLatch;
    logic     rdLoad;
    logic     rdStep;
    logic     commit;
    modKind_t kind;
  } dpCmd_t;
endpackage

// File: rtl/nvm3w_dpath.sv
`timescale 1ns/1ps
module nvm3w_dpath
  import nvm3w_pkg::*;
#(
  parameter int BYTE_AW = 7,
  parameter int BYTE_W  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordMode,
  input  logic       din,
  input  dpCmd_t     cmd,
  output logic [1:0] hdrOp,
  output logic [1:0] hdrSub,
  output logic       rdBit
);
  localparam int WORD_AW = BYTE_AW - 1;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int DEPTH   = 1 << BYTE_AW;
  localparam int SR_W    = (WORD_W > BYTE_AW + 2) ? WORD_W : BYTE_AW + 2;
  localparam int BW      = $clog2(WORD_W + 1);

  logic [SR_W-2:0]    sr;
  logic [SR_W-1:0]    srNext;
  logic [BYTE_W-1:0]  mem [DEPTH];
  logic [BYTE_AW-1:0] fieldAddr, pendIdx, rdIdx, nextIdx;
  logic [WORD_W-1:0]  fieldData, pendData, outSh;
  logic [BW-1:0]      bitsLeft, curW;
  logic               dummy;
  logic [BYTE_W-1:0]  fillLo, fillHi;
  logic [WORD_W-1:0]  oneVal;

  assign srNext = {sr, din};

  always_comb begin
    fieldAddr = wordMode ? {1'b0, srNext[WORD_AW-1:0]} : srNext[BYTE_AW-1:0];
    hdrOp     = wordMode ? srNext[WORD_AW+1:WORD_AW] : srNext[BYTE_AW+1:BYTE_AW];
    hdrSub    = wordMode ? srNext[WORD_AW-1:WORD_AW-2] : srNext[BYTE_AW-1:BYTE_AW-2];
    fieldData = wordMode ? srNext[WORD_W-1:0] : {{BYTE_W{1'b0}}, srNext[BYTE_W-1:0]};
    curW      = wordMode ? BW'(WORD_W) : BW'(BYTE_W);
    nextIdx   = wordMode ? {1'b0, rdIdx[WORD_AW-1:0] + WORD_AW'(1)} : rdIdx + BYTE_AW'(1);
  end

  function automatic logic [WORD_W-1:0] fetch(input logic [BYTE_AW-1:0] idx, input logic wide);
    logic [BYTE_AW-1:0] loA, hiA;
    loA = {idx[WORD_AW-1:0], 1'b0};
    hiA = {idx[WORD_AW-1:0], 1'b1};
    if (wide) fetch = {mem[hiA], mem[loA]};
    else      fetch = {mem[idx], {BYTE_W{1'b0}}};
  endfunction

  // serial capture and read streaming
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sr       <= '0;
      pendIdx  <= '0;
      pendData <= '0;
      rdIdx    <= '0;
      outSh    <= '0;
      bitsLeft <= '0;
      dummy    <= 1'b1;
    end else begin
      if (cmd.shiftEn)  sr       <= srNext[SR_W-2:0];
      if (cmd.adrLatch) pendIdx  <= fieldAddr;
      if (cmd.datLatch) pendData <= fieldData;
      if (cmd.rdLoad) begin
        rdIdx    <= fieldAddr;
        outSh    <= fetch(fieldAddr, wordMode);
        bitsLeft <= curW;
        dummy    <= 1'b1;
      end else if (cmd.rdStep) begin
        if (dummy) begin
          dummy <= 1'b0;
        end else if (bitsLeft == BW'(1)) begin
          rdIdx    <= nextIdx;
          outSh    <= fetch(nextIdx, wordMode);
          bitsLeft <= curW;
        end else begin
          outSh    <= outSh << 1;
          bitsLeft <= bitsLeft - BW'(1);
        end
      end
    end
  end

  assign rdBit = !dummy && outSh[WORD_W-1];

  always_comb begin
    oneVal = (cmd.kind == MOD_ERASE || cmd.kind == MOD_CLEAR) ? '1 : pendData;
    fillLo = oneVal[BYTE_W-1:0];
    fillHi = wordMode ? oneVal[WORD_W-1:BYTE_W] : oneVal[BYTE_W-1:0];
  end

  // storage array: not reset, it models retained cells
  always_ff @(posedge clk) begin
    if (cmd.commit) begin
      if (cmd.kind == MOD_WRITE || cmd.kind == MOD_ERASE) begin
        if (wordMode) begin
          mem[{pendIdx[WORD_AW-1:0], 1'b1}] <= fillHi;
          mem[{pendIdx[WORD_AW-1:0], 1'b0}] <= fillLo;
        end else begin
          mem[pendIdx] <= fillLo;
        end
      end else begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= (i % 2 == 1) ? fillHi : fillLo;
      end
    end
  end
endmodule

// File: rtl/nvm3w_ctrl.sv
`timescale 1ns/1ps
module nvm3w_ctrl
  import nvm3w_pkg::*;
#(
  parameter int BYTE_AW = 7,
  parameter int BYTE_W  = 8,
  parameter int unsigned WORD_CYC = 400000,
  parameter int unsigned BULK_CYC = 1200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cs,
  input  logic       sclk,
  input  logic       din,
  input  logic       wordMode,
  input  logic       lowVdd,
  input  logic [1:0] hdrOp,
  input  logic [1:0] hdrSub,
  input  logic       rdBit,
  output dpCmd_t     cmd,
  output logic       sdoData,
  output logic       sdoEnable,
  output logic       busy,
  output logic       wenQ
);
  localparam int WORD_AW = BYTE_AW - 1;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int CNT_W   = $clog2(2 + WORD_AW + WORD_W + 1);
  localparam int BUSY_W  = $clog2(BULK_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_READ, S_HOLD} phase_t;

  phase_t             st, stN;
  logic               sclkQ, rise;
  logic [CNT_W-1:0]   bitCnt, cntN, hdrLen, fullLen;
  logic [BUSY_W-1:0]  busyCnt, busyN;
  logic               wenN, armed, armedN, statusPend, statN;
  modKind_t           kindQ, kindN;

  assign rise = sclk && !sclkQ;

  always_comb begin
    hdrLen  = (wordMode ? CNT_W'(WORD_AW) : CNT_W'(BYTE_AW)) + CNT_W'(2);
    fullLen = hdrLen + (wordMode ? CNT_W'(WORD_W) : CNT_W'(BYTE_W));
  end

  always_comb begin
    cmd      = '0;
    cmd.kind = kindQ;
    stN      = st;
    cntN     = bitCnt;
    wenN     = wenQ;
    armedN   = armed;
    kindN    = kindQ;
    busyN    = busyCnt;
    statN    = statusPend;
    if (busyCnt != '0) begin
      busyN = busyCnt - BUSY_W'(1);
      if (busyCnt == BUSY_W'(1)) cmd.commit = 1'b1;
    end
    if (!cs) begin
      if (st == S_HOLD && armed && wenQ && !lowVdd) begin
        busyN = (kindQ == MOD_FILL || kindQ == MOD_CLEAR) ? BUSY_W'(BULK_CYC) : BUSY_W'(WORD_CYC);
        statN = 1'b1;
      end
      stN    = S_IDLE;
      armedN = 1'b0;
    end else if (rise) begin
      case (st)
        S_IDLE: if (din && busyCnt == '0) begin
          stN   = S_SHIFT;
          cntN  = '0;
          statN = 1'b0;
        end
        S_SHIFT: begin
          cmd.shiftEn = 1'b1;
          cntN        = bitCnt + CNT_W'(1);
          if (cntN == hdrLen) begin
            case (hdrOp)
              2'b10: begin cmd.rdLoad = 1'b1; stN = S_READ; end
              2'b01: begin cmd.adrLatch = 1'b1; kindN = MOD_WRITE; end
              2'b11: begin cmd.adrLatch = 1'b1; kindN = MOD_ERASE; armedN = 1'b1; stN = S_HOLD; end
              default: begin
                case (hdrSub)
                  2'b11:   begin wenN = 1'b1; stN = S_HOLD; end
                  2'b00:   begin wenN = 1'b0; stN = S_HOLD; end
                  2'b10:   begin kindN = MOD_CLEAR; armedN = 1'b1; stN = S_HOLD; end
                  default: kindN = MOD_FILL;
                endcase
              end
            endcase
          end else if (cntN == fullLen) begin
            cmd.datLatch = 1'b1;
            armedN       = 1'b1;
            stN          = S_HOLD;
          end
        end
        S_READ:  cmd.rdStep = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= S_IDLE;
      sclkQ      <= 1'b0;
      bitCnt     <= '0;
      wenQ       <= 1'b0;
      armed      <= 1'b0;
      kindQ      <= MOD_WRITE;
      busyCnt    <= '0;
      statusPend <= 1'b0;
    end else begin
      st         <= stN;
      sclkQ      <= sclk;
      bitCnt     <= cntN;
      wenQ       <= wenN;
      armed      <= armedN;
      kindQ      <= kindN;
      busyCnt    <= busyN;
      statusPend <= statN;
    end
  end

  assign busy      = busyCnt != '0;
  assign sdoEnable = cs && (st == S_READ || (st == S_IDLE && statusPend));
  assign sdoData   = (st == S_READ) ? rdBit : !busy;
endmodule

// File: rtl/nvm3w_slave.sv
`timescale 1ns/1ps
module nvm3w_slave
  import nvm3w_pkg::*;
#(
  parameter int BYTE_AW = 7,
  parameter int BYTE_W  = 8,
  parameter int unsigned WORD_CYC = 400000,
  parameter int unsigned BULK_CYC = 1200000
) (
  input  logic clk,
  input  logic rstN,
  input  logic cs,
  input  logic sclk,
  input  logic din,
  input  logic orgWide,
  input  logic lowVdd,
  output logic sdoData,
  output logic sdoEnable
);
  dpCmd_t     cmd;
  logic [1:0] hdrOp, hdrSub;
  logic       rdBit, busy, wenQ, shiftStrobe, commitStrobe;

  nvm3w_ctrl #(.BYTE_AW(BYTE_AW), .BYTE_W(BYTE_W), .WORD_CYC(WORD_CYC), .BULK_CYC(BULK_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .cs(cs), .sclk(sclk), .din(din), .wordMode(orgWide),
    .lowVdd(lowVdd), .hdrOp(hdrOp), .hdrSub(hdrSub), .rdBit(rdBit), .cmd(cmd),
    .sdoData(sdoData), .sdoEnable(sdoEnable), .busy(busy), .wenQ(wenQ)
  );

  nvm3w_dpath #(.BYTE_AW(BYTE_AW), .BYTE_W(BYTE_W)) uDpath (
    .clk(clk), .rstN(rstN), .wordMode(orgWide), .din(din), .cmd(cmd),
    .hdrOp(hdrOp), .hdrSub(hdrSub), .rdBit(rdBit)
  );

  assign shiftStrobe  = cmd.shiftEn;
  assign commitStrobe = cmd.commit;
endmodule

// File: rtl/nvm3w_chk.sv
`timescale 1ns/1ps
module nvm3w_chk (
  input logic clk,
  input logic rstN,
  input logic cs,
  input logic lowVdd,
  input logic sdoEnable,
  input logic busy,
  input logic wenQ,
  input logic shiftStrobe,
  input logic commitStrobe
);
  // R5
  sdo_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> (cs || !sdoEnable));

  // R6
  launch_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wenQ));

  // R11
  launch_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(lowVdd));

  // R9
  launch_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(cs));

  // R9
  commit_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(commitStrobe));

  // R10
  busy_noshift_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !shiftStrobe);
endmodule

bind nvm3w_slave nvm3w_chk uChk (
  .clk(clk), .rstN(rstN), .cs(cs), .lowVdd(lowVdd), .sdoEnable(sdoEnable),
  .busy(busy), .wenQ(wenQ), .shiftStrobe(shiftStrobe), .commitStrobe(commitStrobe)
);

// File: tb/sim_nvm3w_slave.sv
`timescale 1ns/1ps
module sim_nvm3w_slave;
  localparam int WORD_CYC = 50;
  localparam int BULK_CYC = 150;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic orgWide = 1'b0, lowVdd = 1'b0;
  logic sdoData, sdoEnable;
  logic lastD, lastE;
  logic [7:0]  bMod [128];
  logic [15:0] wMod [64];
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nvm3w_slave #(.BYTE_AW(7), .BYTE_W(8), .WORD_CYC(WORD_CYC), .BULK_CYC(BULK_CYC)) u0 (
    .clk(clk), .rstN(rstN), .cs(cs), .sclk(sclk), .din(din), .orgWide(orgWide),
    .lowVdd(lowVdd), .sdoData(sdoData), .sdoEnable(sdoEnable)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int aw();
    return orgWide ? 6 : 7;
  endfunction

  function automatic int dw();
    return orgWide ? 16 : 8;
  endfunction

  task automatic sbit(input logic b);
    din = b; sclk = 1'b0; tick(2);
    sclk = 1'b1; tick(2);
    lastD = sdoData; lastE = sdoEnable;
  endtask

  task automatic sendBits(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic csUp();
    sclk = 1'b0; cs = 1'b1; tick(2);
  endtask

  task automatic csDown();
    sclk = 1'b0; cs = 1'b0; din = 1'b0; tick(2);
  endtask

  task automatic head(input int op, input int addr, input int lead);
    csUp();
    repeat (lead) sbit(1'b0);
    sbit(1'b1);
    sendBits(op, 2);
    sendBits(addr, aw());
  endtask

  task automatic special(input int sub);
    head(0, sub << (aw() - 2), 0);
  endtask

  // call right after csDown of a launched command
  task automatic waitReady(input string tag, input int cyc);
    int el;
    el = 2;
    csUp();
    el += 2;
    check({tag, " busy reported"}, {sdoEnable, sdoData}, 2'b10);
    while (!(sdoEnable && sdoData) && el < cyc + 100) begin
      tick(1);
      el++;
    end
    check({tag, " ready within window"}, int'(el >= cyc && el <= cyc + 2), 1);
    csDown();
  endtask

  task automatic writeOp(input int addr, input int data, input int lead);
    head(1, addr, lead);
    sendBits(data, dw());
    csDown();
    waitReady("R9 write", WORD_CYC);
  endtask

  task automatic readRun(input string tag, input int addr, input int n);
    int depth;
    depth = orgWide ? 64 : 128;
    head(2, addr, 0);
    check({tag, " R4 dummy bit"}, {lastE, lastD}, 2'b10);
    for (int k = 0; k < n; k++) begin
      int v, idx, ex;
      v = 0;
      for (int b = 0; b < dw(); b++) begin
        sbit(1'b0);
        v = (v << 1) | int'(lastD);
      end
      idx = (addr + k) % depth;
      ex  = orgWide ? int'(wMod[idx]) : int'(bMod[idx]);
      check($sformatf("%s at %0d", tag, idx), v, ex);
    end
    csDown();
  endtask

  initial begin
    @(negedge clk);
    tick(4);
    check("R5 output released in reset", sdoEnable, 0);
    rstN = 1'b1;
    tick(2);
    check("R5 output released after reset", sdoEnable, 0);

    // R6: permission is clear after reset
    special(2); csDown(); csUp();
    check("R6 erase-all refused after reset", sdoEnable, 0);
    csDown();

    special(3); csDown();
    special(2); csDown();
    waitReady("R9 R7 erase-all", BULK_CYC);
    for (int i = 0; i < 128; i++) bMod[i] = 8'hFF;
    readRun("R7 erased byte", 0, 128);

    // R6: disable blocks writes
    special(0); csDown();
    head(1, 5, 0); sendBits(8'h3C, 8); csDown(); csUp();
    check("R6 disabled write no status", sdoEnable, 0);
    csDown();
    readRun("R6 disabled write", 5, 1);

    // R1 R2: full byte sweep with leading zero clocks
    special(3); csDown();
    for (int a = 0; a < 128; a++) begin
      bMod[a] = 8'((a * 37 + 5) & 255);
      writeOp(a, int'(bMod[a]), a % 3);
    end
    readRun("R1 R2 R3 R4 byte sweep", 0, 130);

    // R11
    lowVdd = 1'b1;
    head(1, 10, 0); sendBits(0, 8); csDown();
    lowVdd = 1'b0;
    csUp();
    check("R11 inhibited write no status", sdoEnable, 0);
    csDown();
    readRun("R11 inhibited write", 10, 1);

    // R12
    head(1, 20, 0); sendBits(0, 4); csDown(); csUp();
    check("R12 aborted write no status", sdoEnable, 0);
    csDown();
    readRun("R12 aborted write", 20, 1);

    // R7 single erase
    head(3, 30, 0); csDown();
    waitReady("R9 erase", WORD_CYC);
    bMod[30] = 8'hFF;
    readRun("R7 single erase", 29, 3);

    // R10: disable sent during busy is ignored
    head(1, 40, 0); sendBits(8'h5A, 8); csDown();
    csUp();
    sbit(1'b1); sendBits(0, 2); sendBits(0, 7);
    check("R10 status kept during busy", {lastE, lastD}, 2'b10);
    csDown();
    csUp();
    for (int g = 0; g < 200 && !(sdoEnable && sdoData); g++) tick(1);
    csDown();
    bMod[40] = 8'h5A;
    bMod[41] = 8'hA5;
    writeOp(41, 8'hA5, 0);
    readRun("R10 command during busy ignored", 40, 2);

    // word organization
    orgWide = 1'b1;
    tick(2);
    special(3); csDown();
    special(1); sendBits(16'h1234, 16); csDown();
    waitReady("R9 write-all", BULK_CYC);
    for (int i = 0; i < 64; i++) wMod[i] = 16'h1234;
    readRun("R8 R3 write-all", 0, 66);

    for (int a = 0; a < 64; a++) begin
      wMod[a] = 16'((a * 613 + 77) & 16'hFFFF);
      writeOp(a, int'(wMod[a]), 0);
    end
    readRun("R3 R4 word sweep", 0, 64);
    readRun("R4 word wrap", 60, 8);

    head(3, 7, 0); csDown();
    waitReady("R9 word erase", WORD_CYC);
    wMod[7] = 16'hFFFF;
    readRun("R7 word erase", 6, 3);

    special(0); csDown();
    head(1, 9, 0); sendBits(0, 16); csDown();
    readRun("R6 word disabled write", 9, 1);

    special(3); csDown();
    special(2); csDown();
    waitReady("R9 word erase-all", BULK_CYC);
    for (int i = 0; i < 64; i++) wMod[i] = 16'hFFFF;
    readRun("R7 word erase-all", 62, 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule